// File: doc/BRIEF.md
# Power-Stage Fault and Enable Supervisor

This block decides when the bridges of a two-phase motor driver may conduct. It watches a shared enable line: outside logic can hold the line low, and the block can pull it low through an open-drain device. It also takes one overcurrent or short-circuit flag per bridge and a junction temperature code. From these it drives a power-stage enable and a pull-down request for the open-drain device. The line level reaches the block as three sampled comparator flags: logic high, logic low, and below the release level.

After reset, and each time standby is left, the block holds the line low until the analog side reports that it has stabilised. An overcurrent fault keeps the line pulled low until the line has discharged below the release level. The pull-down is then let go, so the delay before restart is set by the external RC network. The stage comes back only when the line reads high again. A thermal fault works another way: it trips at a fixed temperature code and clears when the temperature falls below a lower code, whatever the line is doing. A sticky register records which faults have occurred since the last standby.

Top module: `fault_enable_supervisor`

## Requirements
- R1: After reset, or when `standby` falls, `pullDown` is 1 and `stageEnable` is 0 until `stableDone` is sampled high at a clock edge; `pullDown` is 0 from that edge on, unless a fault is present.
- R2: While `standby` is 1, `stageEnable` and `pullDown` are both 0 in the same cycle, whatever the other inputs are. The first clock edge with `standby` high clears every latched fault and `faultCause`.
- R3: An overcurrent flag on any bridge (`ocEvent[b]` = 1) forces `stageEnable` to 0 and `pullDown` to 1 in the same cycle.
- R4: After an overcurrent, `pullDown` stays 1 until a clock edge samples `lineBelowRelease` = 1 while no thermal fault is held and no `ocEvent` is set. From that edge on, `pullDown` is 0.
- R5: `stageEnable` is 1 only when the block is running with no fault present and the line reads high (`lineHigh` = 1 and `lineLow` = 0). After a fault clears, the block returns to running one clock edge after the pull-down is released.
- R6: If the line is held low from outside while no fault is present, `stageEnable` is 0 and `pullDown` stays 0.
- R7: When `tempCode` >= TRIP_CODE (default 160), `stageEnable` goes to 0 and `pullDown` to 1 in the same cycle. A code of TRIP_CODE-1 has no effect.
- R8: A thermal fault stays held while `tempCode` >= CLEAR_CODE (default 120). It clears at the first edge that samples a lower code, with no condition on the line level, and `pullDown` falls from that edge on.
- R9: If an overcurrent is latched while a thermal fault is held, the overcurrent is not released at the edge where the thermal fault clears. It is released only at a later edge that samples `lineBelowRelease` = 1.
- R10: `faultCause` bit b (b < NUM_BRIDGES) is set by `ocEvent[b]`, and bit NUM_BRIDGES (bit 2 by default) is set by a thermal trip. Each bit is set from the edge after its event and stays set until standby or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low; same effect as a power-up |
| standby | input | 1 | Low-consumption request, active high |
| stableDone | input | 1 | The analog side has stabilised after power-up or standby exit |
| lineHigh | input | 1 | Enable line sampled above the logic-high threshold |
| lineLow | input | 1 | Enable line sampled below the logic-low threshold |
| lineBelowRelease | input | 1 | Enable line sampled below the release level |
| ocEvent | input | NUM_BRIDGES | Overcurrent or short-circuit flag, one bit per bridge |
| tempCode | input | TEMP_W | Junction temperature code, one unit per degree |
| stageEnable | output | 1 | The power bridges may conduct |
| pullDown | output | 1 | Turn on the open-drain pull-down of the enable line |
| faultCause | output | NUM_BRIDGES+1 | Sticky fault record: bridge overcurrent bits, thermal bit on top |

## Verification
A bad internal state shows up at the ports in a known way. An overcurrent latch that is lost drops `pullDown` at the next edge while the line is still above the release level. An overcurrent latch that is never cleared keeps `pullDown` high after the line has crossed the release level and the temperature is normal. A thermal flag with a wrong threshold shows up in the same cycle, at code 159/160, or at the edge that samples 120 or 119. A wrong FSM state appears as `stageEnable` coming back one edge too early or too late after a release. A stuck or lost cause bit is visible on `faultCause` one edge after its event, or after standby.

// File: rtl/fes_pkg.sv
`timescale 1ns/1ps
package fes_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic clearAll;   // standby: return every register to its power-up value
    logic captureOc;  // latch a bridge overcurrent flag
    logic releaseOc;  // drop the overcurrent latch
  } supStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic ocAny;      // some bridge flags overcurrent in this cycle
    logic ocLatch;    // overcurrent waiting for the line to discharge
    logic thermTrip;  // temperature at or above the trip code now
    logic thermHot;   // thermal fault held (hysteresis)
  } supStatus_t;

  typedef enum logic [1:0] {
    ST_STARTUP = 2'd0,
    ST_RUN     = 2'd1,
    ST_HOLD    = 2'd2
  } supState_t;

endpackage

// File: rtl/fes_datapath.sv
`timescale 1ns/1ps
module fes_datapath
  import fes_pkg::*;
#(
  parameter int NUM_BRIDGES = 2,
  parameter int TEMP_W      = 8,
  parameter int TRIP_CODE   = 160,
  parameter int CLEAR_CODE  = 120
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  supStrobe_t             strobe,
  input  logic [NUM_BRIDGES-1:0] ocEvent,
  input  logic [TEMP_W-1:0]      tempCode,
  output supStatus_t             status,
  output logic [NUM_BRIDGES:0]   faultCause
);

  localparam logic [TEMP_W-1:0] TRIP_LVL  = TEMP_W'(TRIP_CODE);
  localparam logic [TEMP_W-1:0] CLEAR_LVL = TEMP_W'(CLEAR_CODE);
  localparam int                THERM_BIT = NUM_BRIDGES;

  logic ocAny;
  logic thermTrip;
  logic thermCool;
  logic thermHot;
  logic ocLatch;

  assign ocAny     = |ocEvent;
  assign thermTrip = (tempCode >= TRIP_LVL);
  assign thermCool = (tempCode < CLEAR_LVL);

  // thermal hysteresis flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                thermHot <= 1'b0;
    else if (strobe.clearAll) thermHot <= 1'b0;
    else if (thermTrip)       thermHot <= 1'b1;
    else if (thermCool)       thermHot <= 1'b0;
  end

  // overcurrent latch; a new event wins over a release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         ocLatch <= 1'b0;
    else if (strobe.clearAll)          ocLatch <= 1'b0;
    else if (strobe.captureOc && ocAny) ocLatch <= 1'b1;
    else if (strobe.releaseOc)         ocLatch <= 1'b0;
  end

  // sticky cause record, one bit per bridge
  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_ocCause
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                faultCause[b] <= 1'b0;
      else if (strobe.clearAll) faultCause[b] <= 1'b0;
      else if (ocEvent[b])      faultCause[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                faultCause[THERM_BIT] <= 1'b0;
    else if (strobe.clearAll) faultCause[THERM_BIT] <= 1'b0;
    else if (thermTrip)       faultCause[THERM_BIT] <= 1'b1;
  end

  assign status.ocAny     = ocAny;
  assign status.ocLatch   = ocLatch;
  assign status.thermTrip = thermTrip;
  assign status.thermHot  = thermHot;

endmodule

// File: rtl/fes_control.sv
`timescale 1ns/1ps
module fes_control
  import fes_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       standby,
  input  logic       stableDone,
  input  logic       lineHigh,
  input  logic       lineLow,
  input  logic       lineBelowRelease,
  input  supStatus_t status,
  output supStrobe_t strobe,
  output logic       stageEnable,
  output logic       pullDown
);

  supState_t state;
  supState_t stateNext;
  logic      faultNow;
  logic      lineReadsHigh;

  assign faultNow      = status.ocAny | status.ocLatch | status.thermTrip | status.thermHot;
  assign lineReadsHigh = lineHigh & ~lineLow;

  always_comb begin
    stateNext = state;
    if (standby) begin
      stateNext = ST_STARTUP;
    end else begin
      unique case (state)
        ST_STARTUP: if (stableDone) stateNext = ST_RUN;
        ST_RUN:     if (faultNow)   stateNext = ST_HOLD;
        ST_HOLD:    if (!faultNow)  stateNext = ST_RUN;
        default:                    stateNext = ST_STARTUP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_STARTUP;
    else       state <= stateNext;
  end

  // strobes: thermal release has priority over the overcurrent release
  always_comb begin
    strobe.clearAll  = standby;
    strobe.captureOc = ~standby;
    strobe.releaseOc = ~standby & (state == ST_HOLD) & lineBelowRelease
                       & ~status.thermHot & ~status.ocAny;
  end

  assign pullDown    = ~standby & ((state == ST_STARTUP) | faultNow);
  assign stageEnable = ~standby & (state == ST_RUN) & lineReadsHigh & ~faultNow;

endmodule

// File: rtl/fault_enable_supervisor.sv
`timescale 1ns/1ps
module fault_enable_supervisor
  import fes_pkg::*;
#(
  parameter int NUM_BRIDGES = 2,
  parameter int TEMP_W      = 8,
  parameter int TRIP_CODE   = 160,
  parameter int CLEAR_CODE  = 120
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   standby,
  input  logic                   stableDone,
  input  logic                   lineHigh,
  input  logic                   lineLow,
  input  logic                   lineBelowRelease,
  input  logic [NUM_BRIDGES-1:0] ocEvent,
  input  logic [TEMP_W-1:0]      tempCode,
  output logic                   stageEnable,
  output logic                   pullDown,
  output logic [NUM_BRIDGES:0]   faultCause
);

  supStrobe_t strobeBus;
  supStatus_t statusBus;
  logic       ocHeld;

  fes_datapath #(
    .NUM_BRIDGES(NUM_BRIDGES),
    .TEMP_W     (TEMP_W),
    .TRIP_CODE  (TRIP_CODE),
    .CLEAR_CODE (CLEAR_CODE)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobeBus),
    .ocEvent   (ocEvent),
    .tempCode  (tempCode),
    .status    (statusBus),
    .faultCause(faultCause)
  );

  fes_control ctl_i (
    .clk             (clk),
    .rstN            (rstN),
    .standby         (standby),
    .stableDone      (stableDone),
    .lineHigh        (lineHigh),
    .lineLow         (lineLow),
    .lineBelowRelease(lineBelowRelease),
    .status          (statusBus),
    .strobe          (strobeBus),
    .stageEnable     (stageEnable),
    .pullDown        (pullDown)
  );

  assign ocHeld = statusBus.ocLatch;

endmodule

// File: rtl/fes_checker.sv
`timescale 1ns/1ps
module fes_checker #(
  parameter int NUM_BRIDGES = 2,
  parameter int TEMP_W      = 8,
  parameter int TRIP_CODE   = 160
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   standby,
  input logic                   lineHigh,
  input logic                   lineLow,
  input logic                   lineBelowRelease,
  input logic [NUM_BRIDGES-1:0] ocEvent,
  input logic [TEMP_W-1:0]      tempCode,
  input logic                   stageEnable,
  input logic                   pullDown,
  input logic [NUM_BRIDGES:0]   faultCause,
  input logic                   ocHeld
);

  localparam logic [TEMP_W-1:0] TRIP_LVL = TEMP_W'(TRIP_CODE);

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> (!stageEnable && !pullDown));

  assert_oc_cut_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((|ocEvent) && !standby) |-> (!stageEnable && pullDown));

  assert_oc_hold_R4: assert property (@(posedge clk) disable iff (!rstN || standby)
    (ocHeld && !lineBelowRelease) |=> pullDown);

  assert_line_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    stageEnable |-> (lineHigh && !lineLow && !pullDown));

  assert_hot_cut_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((tempCode >= TRIP_LVL) && !standby) |-> (pullDown && !stageEnable));

  assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    !standby |=> ((faultCause & $past(faultCause)) == $past(faultCause)));

endmodule

bind fault_enable_supervisor fes_checker #(
  .NUM_BRIDGES(NUM_BRIDGES),
  .TEMP_W     (TEMP_W),
  .TRIP_CODE  (TRIP_CODE)
) chk_i (
  .clk             (clk),
  .rstN            (rstN),
  .standby         (standby),
  .lineHigh        (lineHigh),
  .lineLow         (lineLow),
  .lineBelowRelease(lineBelowRelease),
  .ocEvent         (ocEvent),
  .tempCode        (tempCode),
  .stageEnable     (stageEnable),
  .pullDown        (pullDown),
  .faultCause      (faultCause),
  .ocHeld          (ocHeld)
);

// File: tb/fault_enable_supervisor_tb_top.sv
`timescale 1ns/1ps
module fault_enable_supervisor_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       standby = 1'b0;
  logic       stableDone = 1'b0;
  logic       lineHigh = 1'b0;
  logic       lineLow = 1'b1;
  logic       lineBelowRelease = 1'b0;
  logic [1:0] ocEvent = 2'b00;
  logic [7:0] tempCode = 8'd25;
  logic       stageEnable;
  logic       pullDown;
  logic [2:0] faultCause;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fault_enable_supervisor dut_i (
    .clk(clk), .rstN(rstN), .standby(standby), .stableDone(stableDone),
    .lineHigh(lineHigh), .lineLow(lineLow), .lineBelowRelease(lineBelowRelease),
    .ocEvent(ocEvent), .tempCode(tempCode),
    .stageEnable(stageEnable), .pullDown(pullDown), .faultCause(faultCause)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic outs(input string tag, input logic en, input logic pd);
    chk({tag, " stageEnable"}, {2'b00, stageEnable}, {2'b00, en});
    chk({tag, " pullDown"}, {2'b00, pullDown}, {2'b00, pd});
  endtask

  task automatic lineUp();
    lineHigh = 1'b1; lineLow = 1'b0; lineBelowRelease = 1'b0;
  endtask

  task automatic lineDown();
    lineHigh = 1'b0; lineLow = 1'b1; lineBelowRelease = 1'b1;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic testReset();
    tick(2);
    rstN = 1'b1;
    tick(2);
    outs("R1 startup hold", 1'b0, 1'b1);
    chk("R1 cause after reset", faultCause, 3'b000);
    lineUp();
    stableDone = 1'b1;
    settle();
    outs("R1 before edge", 1'b0, 1'b1);
    tick(1);
    outs("R1 running", 1'b1, 1'b0);
  endtask

  task automatic testExternalLow();
    lineHigh = 1'b0; lineLow = 1'b1;
    settle();
    outs("R6 external low", 1'b0, 1'b0);
    tick(3);
    outs("R6 external low held", 1'b0, 1'b0);
    chk("R6 no cause", faultCause, 3'b000);
    lineUp();
    settle();
    outs("R5 line high again", 1'b1, 1'b0);
  endtask

  task automatic testOvercurrent();
    ocEvent = 2'b01;
    settle();
    outs("R3 oc immediate", 1'b0, 1'b1);
    tick(1);
    ocEvent = 2'b00;
    chk("R10 cause bridge A", faultCause, 3'b001);
    tick(4);
    outs("R4 held above release", 1'b0, 1'b1);
    lineDown();
    tick(1);
    outs("R4 released", 1'b0, 1'b0);
    lineUp();
    settle();
    outs("R5 not yet running", 1'b0, 1'b0);
    tick(1);
    outs("R5 running after release", 1'b1, 1'b0);
  endtask

  task automatic testThermal();
    tempCode = 8'd159;
    settle();
    outs("R7 code 159 no effect", 1'b1, 1'b0);
    tempCode = 8'd160;
    settle();
    outs("R7 trip at 160", 1'b0, 1'b1);
    tick(1);
    chk("R10 cause thermal", faultCause, 3'b101);
    tempCode = 8'd120;
    lineHigh = 1'b0; lineLow = 1'b1; lineBelowRelease = 1'b0;
    tick(3);
    outs("R8 held at 120", 1'b0, 1'b1);
    tempCode = 8'd119;
    tick(1);
    outs("R8 released at 119", 1'b0, 1'b0);
    lineUp();
    tick(1);
    outs("R8 running again", 1'b1, 1'b0);
  endtask

  task automatic testPriority();
    tempCode = 8'd170;
    tick(1);
    lineDown();
    ocEvent = 2'b10;
    tick(1);
    ocEvent = 2'b00;
    tick(2);
    outs("R9 both faults held", 1'b0, 1'b1);
    chk("R10 cause all", faultCause, 3'b111);
    tempCode = 8'd100;
    tick(1);
    outs("R9 oc still held after thermal clear", 1'b0, 1'b1);
    tick(1);
    outs("R9 released after thermal", 1'b0, 1'b0);
    chk("R10 cause sticky", faultCause, 3'b111);
    lineUp();
    tick(1);
    outs("R5 running after priority", 1'b1, 1'b0);
  endtask

  task automatic testStandby();
    standby = 1'b1;
    stableDone = 1'b0;
    ocEvent = 2'b01;
    tempCode = 8'd200;
    settle();
    outs("R2 standby quiet", 1'b0, 1'b0);
    tick(1);
    chk("R2 cause cleared", faultCause, 3'b000);
    tick(2);
    outs("R2 standby held", 1'b0, 1'b0);
    ocEvent = 2'b00;
    tempCode = 8'd25;
    tick(1);
    chk("R10 cleared by standby", faultCause, 3'b000);
    standby = 1'b0;
    settle();
    outs("R1 standby exit hold", 1'b0, 1'b1);
    tick(3);
    outs("R1 waiting stable", 1'b0, 1'b1);
    stableDone = 1'b1;
    tick(1);
    outs("R1 run after standby", 1'b1, 1'b0);
    chk("R2 no stale fault", faultCause, 3'b000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    @(negedge clk);
    testReset();
    testExternalLow();
    testOvercurrent();
    testThermal();
    testPriority();
    testStandby();
    report();
  end

endmodule